// File: doc/BRIEF.md
# Quadrature Direction-Pulse Position Counter

This block turns the two phase signals of an incremental rotary encoder into a signed shaft position. Each phase is brought into the clock domain by a short synchronizer and then passes through a programmable 16-entry truth-table cell with separate rise and fall glitch filters. The two filtered phases, together with their values from the previous clock, index two more truth-table cells. These cells emit one-clock step pulses, one cell for each direction of rotation.

Each step stream feeds its own up-counter, and the two counters are independent. A counter starts at 1, runs up to a fixed maximum, and then wraps back to 1. Every wrap adds one to an overflow tally for that counter. A snapshot strobe copies both counters and both tallies at the same moment, so they are always read together. The signed position is formed from that copy: the clockwise total minus the counter-clockwise total, where each total is the count plus the maximum multiplied by the tally.

The decode enable clears all four table outputs while it is low.

Top module: `quad_pos_counter`

## Requirements
- R1: After synchronous reset, both snapshot counts read 1, both tallies read 0, position reads 0, and `filt_a`, `filt_b`, `cw_step` and `ccw_step` are low.
- R2: While `dec_en` is low, all four table outputs (`filt_a`, `filt_b`, `cw_step`, `ccw_step`) are held low whatever the phases do, and no step is counted.
- R3: A phase table output takes a new value only when its table input has held that value for more than L consecutive clocks. L is `flt_rise` for a change to 1 and `flt_fall` for a change to 0. A change lasting L clocks or fewer leaves the output and the step counts untouched.
- R4: The step tables are indexed by {A_prev, B_prev, A_now, B_now} of the filtered phases, with B_now as bit 0. `cw_step` uses table 16'h2814, which is true for A-leading transitions (AB 00→10→11→01→00). `ccw_step` uses 16'h4182, which is true for B-leading transitions. `filt_b` uses 16'hAAAA and `filt_a` uses 16'hCCCC over the synchronized phases. Each single-phase transition gives exactly one pulse in the matching direction.
- R5: Each rising edge of a step output advances its counter by one. Counters run through 1..CNT_MAX and go from CNT_MAX back to 1.
- R6: Each wrap from CNT_MAX to 1 increments that counter's tally by exactly one. The tally changes at no other time.
- R7: `position` = (cw_cnt + CNT_MAX·cw_ovf) − (ccw_cnt + CNT_MAX·ccw_ovf), computed from the snapshot values as a signed POS_W-bit number.
- R8: The four snapshot outputs change only on the clock after `snap` is sampled high, and all four load on that same edge.
- R9: `cw_step` and `ccw_step` are never high in the same cycle. A transition in which both phases change together produces no step in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_en | input | 1 | Enable for the four truth-table cells |
| phase_a | input | 1 | Raw encoder phase A (asynchronous) |
| phase_b | input | 1 | Raw encoder phase B (asynchronous) |
| flt_rise | input | FLT_W | Rise filter length for the phase cells |
| flt_fall | input | FLT_W | Fall filter length for the phase cells |
| snap | input | 1 | Snapshot strobe |
| filt_a | output | 1 | Filtered phase A |
| filt_b | output | 1 | Filtered phase B |
| cw_step | output | 1 | Clockwise step pulse |
| ccw_step | output | 1 | Counter-clockwise step pulse |
| cw_cnt | output | CNT_W | Snapshot of the clockwise counter |
| ccw_cnt | output | CNT_W | Snapshot of the counter-clockwise counter |
| cw_ovf | output | OVF_W | Snapshot of the clockwise overflow tally |
| ccw_ovf | output | OVF_W | Snapshot of the counter-clockwise overflow tally |
| position | output | POS_W | Signed position from the snapshot values |

## Verification
A snapshot strobe can land on the same clock edge as a counter increment, including the increment that wraps the counter and bumps its tally. The bench provokes this by holding `snap` high without a break while it steps the encoder clockwise across two wraps. It then examines every cycle of the snapshot outputs. In each cycle the position must either hold or rise by exactly one, and the count and tally pair must agree with the position formula. A torn copy, where the counter has wrapped but the tally has not yet moved, would show up as a jump of about CNT_MAX.

// File: rtl/quad_pos_pkg.sv
package quad_pos_pkg;

    // Identity of each truth-table cell; the value is its bit in the decode word.
    typedef enum logic [1:0] {
        CELL_PH_B     = 2'd0,
        CELL_PH_A     = 2'd1,
        CELL_STEP_CCW = 2'd2,
        CELL_STEP_CW  = 2'd3
    } cell_id_e;

    localparam int NUM_CELLS = 4;
    localparam int IDX_W     = 4;

    // Decode word: field order matches the cell ids above (MSB first).
    typedef struct packed {
        logic step_cw;
        logic step_ccw;
        logic ph_a;
        logic ph_b;
    } decode_t;

    // Truth table contents for each cell.
    function automatic logic [15:0] cell_table(input int id);
        case (id)
            int'(CELL_PH_B):     return 16'hAAAA;
            int'(CELL_PH_A):     return 16'hCCCC;
            int'(CELL_STEP_CCW): return 16'h4182;
            int'(CELL_STEP_CW):  return 16'h2814;
            default:             return 16'h0000;
        endcase
    endfunction

    // Overflow-extended difference of the two direction totals.
    function automatic logic signed [63:0] extend_position(
        input logic [63:0] cw,
        input logic [63:0] cw_wraps,
        input logic [63:0] ccw,
        input logic [63:0] ccw_wraps,
        input logic [63:0] wrap_weight
    );
        logic [63:0] cw_total;
        logic [63:0] ccw_total;
        cw_total  = cw  + wrap_weight * cw_wraps;
        ccw_total = ccw + wrap_weight * ccw_wraps;
        return signed'(cw_total - ccw_total);
    endfunction

endpackage

// File: rtl/quad_pos_sync.sv
module quad_pos_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/quad_pos_lut_cell.sv
module quad_pos_lut_cell #(
    parameter logic [15:0] TABLE = 16'hAAAA,
    parameter int          FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [3:0]       idx,
    input  logic [FLT_W-1:0] rise_len,
    input  logic [FLT_W-1:0] fall_len,
    output logic             q
);
    logic             cand;
    logic [FLT_W-1:0] run;
    logic [FLT_W-1:0] need;

    always_comb begin
        cand = TABLE[idx];
        need = cand ? rise_len : fall_len;
    end

    // A candidate differing from q must survive need+1 edges to be taken.
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            q   <= 1'b0;
            run <= '0;
        end else if (cand == q) begin
            run <= '0;
        end else if (run >= need) begin
            q   <= cand;
            run <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/quad_pos_edge_counter.sv
module quad_pos_edge_counter #(
    parameter int               CNT_W   = 16,
    parameter int               OVF_W   = 16,
    parameter logic [CNT_W-1:0] CNT_MAX = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse,
    output logic [CNT_W-1:0] cnt,
    output logic [OVF_W-1:0] ovf
);
    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(1);

    logic pulse_d;
    logic hit;

    assign hit = pulse & ~pulse_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_d <= 1'b0;
            cnt     <= CNT_START;
            ovf     <= '0;
        end else begin
            pulse_d <= pulse;
            if (hit) begin
                if (cnt == CNT_MAX) begin
                    cnt <= CNT_START;
                    ovf <= ovf + 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import quad_pos_pkg::*;
#(
    parameter int               CNT_W       = 16,
    parameter int               OVF_W       = 16,
    parameter int               POS_W       = 32,
    parameter int               FLT_W       = 4,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CNT_W-1:0] CNT_MAX     = '1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    dec_en,
    input  logic                    phase_a,
    input  logic                    phase_b,
    input  logic [FLT_W-1:0]        flt_rise,
    input  logic [FLT_W-1:0]        flt_fall,
    input  logic                    snap,
    output logic                    filt_a,
    output logic                    filt_b,
    output logic                    cw_step,
    output logic                    ccw_step,
    output logic [CNT_W-1:0]        cw_cnt,
    output logic [CNT_W-1:0]        ccw_cnt,
    output logic [OVF_W-1:0]        cw_ovf,
    output logic [OVF_W-1:0]        ccw_ovf,
    output logic signed [POS_W-1:0] position
);
    localparam logic [FLT_W-1:0] NO_FILTER = '0;
    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(1);

    // Synchronized raw phases, bit 1 = A, bit 0 = B
    logic [1:0]           sync_ab;
    logic [1:0]           sync_ab_prev;
    logic [IDX_W-1:0]     raw_idx;
    logic [IDX_W-1:0]     step_idx;
    logic [NUM_CELLS-1:0] dec_bits;
    decode_t              dec;
    logic                 fa_prev;
    logic                 fb_prev;

    logic [CNT_W-1:0]     live_cw_cnt;
    logic [CNT_W-1:0]     live_ccw_cnt;
    logic [OVF_W-1:0]     live_cw_ovf;
    logic [OVF_W-1:0]     live_ccw_ovf;
    logic signed [63:0]   pos_wide;

    quad_pos_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({phase_a, phase_b}),
        .q   (sync_ab)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_ab_prev <= 2'b00;
            fa_prev      <= 1'b0;
            fb_prev      <= 1'b0;
        end else begin
            sync_ab_prev <= sync_ab;
            fa_prev      <= dec.ph_a;
            fb_prev      <= dec.ph_b;
        end
    end

    always_comb begin
        raw_idx  = {sync_ab_prev, sync_ab};
        dec      = decode_t'(dec_bits);
        step_idx = {fa_prev, fb_prev, dec.ph_a, dec.ph_b};
    end

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        if (i >= int'(CELL_STEP_CCW)) begin : g_step
            quad_pos_lut_cell #(.TABLE(cell_table(i)), .FLT_W(FLT_W)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .en       (dec_en),
                .idx      (step_idx),
                .rise_len (NO_FILTER),
                .fall_len (NO_FILTER),
                .q        (dec_bits[i])
            );
        end else begin : g_phase
            quad_pos_lut_cell #(.TABLE(cell_table(i)), .FLT_W(FLT_W)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .en       (dec_en),
                .idx      (raw_idx),
                .rise_len (flt_rise),
                .fall_len (flt_fall),
                .q        (dec_bits[i])
            );
        end
    end

    assign filt_a   = dec.ph_a;
    assign filt_b   = dec.ph_b;
    assign cw_step  = dec.step_cw;
    assign ccw_step = dec.step_ccw;

    quad_pos_edge_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W), .CNT_MAX(CNT_MAX)) u_cw_ctr (
        .clk   (clk),
        .rst   (rst),
        .pulse (dec.step_cw),
        .cnt   (live_cw_cnt),
        .ovf   (live_cw_ovf)
    );

    quad_pos_edge_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W), .CNT_MAX(CNT_MAX)) u_ccw_ctr (
        .clk   (clk),
        .rst   (rst),
        .pulse (dec.step_ccw),
        .cnt   (live_ccw_cnt),
        .ovf   (live_ccw_ovf)
    );

    // Coherent copy of all four counting registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cw_cnt  <= CNT_START;
            ccw_cnt <= CNT_START;
            cw_ovf  <= '0;
            ccw_ovf <= '0;
        end else if (snap) begin
            cw_cnt  <= live_cw_cnt;
            ccw_cnt <= live_ccw_cnt;
            cw_ovf  <= live_cw_ovf;
            ccw_ovf <= live_ccw_ovf;
        end
    end

    always_comb begin
        pos_wide = extend_position(64'(cw_cnt), 64'(cw_ovf), 64'(ccw_cnt),
                                   64'(ccw_ovf), 64'(CNT_MAX));
        position = pos_wide[POS_W-1:0];
    end
endmodule

// File: rtl/quad_pos_counter_chk.sv
module quad_pos_counter_chk #(
    parameter int               CNT_W   = 16,
    parameter int               OVF_W   = 16,
    parameter logic [CNT_W-1:0] CNT_MAX = '1
) (
    input logic             clk,
    input logic             rst,
    input logic             dec_en,
    input logic             snap,
    input logic             filt_a,
    input logic             filt_b,
    input logic             cw_step,
    input logic             ccw_step,
    input logic [CNT_W-1:0] cw_cnt,
    input logic [CNT_W-1:0] ccw_cnt,
    input logic [OVF_W-1:0] cw_ovf,
    input logic [OVF_W-1:0] ccw_ovf,
    input logic [CNT_W-1:0] live_cw_cnt,
    input logic [OVF_W-1:0] live_cw_ovf
);
    // R1: values on the first cycle out of reset
    p_reset_values_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cw_cnt == CNT_W'(1) && ccw_cnt == CNT_W'(1)
                        && cw_ovf == '0 && ccw_ovf == '0));

    // R2: disabled cells stay low
    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        !dec_en |=> (!filt_a && !filt_b && !cw_step && !ccw_step));

    // R5: counters stay inside 1..CNT_MAX
    p_count_range_r5: assert property (@(posedge clk) disable iff (rst)
        (live_cw_cnt >= CNT_W'(1) && live_cw_cnt <= CNT_MAX
         && cw_cnt >= CNT_W'(1) && ccw_cnt >= CNT_W'(1)
         && cw_cnt <= CNT_MAX && ccw_cnt <= CNT_MAX));

    // R5: the counter moves only after a step pulse
    p_count_after_step_r5: assert property (@(posedge clk) disable iff (rst)
        (live_cw_cnt != $past(live_cw_cnt)) |-> $past(cw_step));

    // R6: tally moves only on a wrap from CNT_MAX to 1
    p_wrap_tally_r6: assert property (@(posedge clk) disable iff (rst)
        (live_cw_ovf != $past(live_cw_ovf)) |->
            (live_cw_cnt == CNT_W'(1) && $past(live_cw_cnt) == CNT_MAX));

    // R8: snapshot outputs hold without a strobe
    p_snap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !snap |=> ($stable(cw_cnt) && $stable(ccw_cnt)
                   && $stable(cw_ovf) && $stable(ccw_ovf)));

    // R9: directions are exclusive
    p_step_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(cw_step && ccw_step));
endmodule

bind quad_pos_counter quad_pos_counter_chk #(
    .CNT_W   (CNT_W),
    .OVF_W   (OVF_W),
    .CNT_MAX (CNT_MAX)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dec_en      (dec_en),
    .snap        (snap),
    .filt_a      (filt_a),
    .filt_b      (filt_b),
    .cw_step     (cw_step),
    .ccw_step    (ccw_step),
    .cw_cnt      (cw_cnt),
    .ccw_cnt     (ccw_cnt),
    .cw_ovf      (cw_ovf),
    .ccw_ovf     (ccw_ovf),
    .live_cw_cnt (live_cw_cnt),
    .live_cw_ovf (live_cw_ovf)
);

// File: tb/quad_pos_counter_bench.sv
module quad_pos_counter_bench;
    localparam int               CNT_W   = 16;
    localparam int               OVF_W   = 8;
    localparam int               POS_W   = 32;
    localparam int               FLT_W   = 4;
    localparam logic [CNT_W-1:0] CNT_MAX = 16'd7;
    localparam int               HOLD    = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dec_en = 1'b0;
    logic phase_a = 1'b0;
    logic phase_b = 1'b0;
    logic [FLT_W-1:0] flt_rise = '0;
    logic [FLT_W-1:0] flt_fall = '0;
    logic snap = 1'b0;
    logic filt_a, filt_b, cw_step, ccw_step;
    logic [CNT_W-1:0] cw_cnt, ccw_cnt;
    logic [OVF_W-1:0] cw_ovf, ccw_ovf;
    logic signed [POS_W-1:0] position;

    always #10 clk = ~clk;

    quad_pos_counter #(
        .CNT_W(CNT_W), .OVF_W(OVF_W), .POS_W(POS_W), .FLT_W(FLT_W),
        .SYNC_STAGES(2), .CNT_MAX(CNT_MAX)
    ) u_quad_pos_counter (
        .clk(clk), .rst(rst), .dec_en(dec_en), .phase_a(phase_a), .phase_b(phase_b),
        .flt_rise(flt_rise), .flt_fall(flt_fall), .snap(snap),
        .filt_a(filt_a), .filt_b(filt_b), .cw_step(cw_step), .ccw_step(ccw_step),
        .cw_cnt(cw_cnt), .ccw_cnt(ccw_cnt), .cw_ovf(cw_ovf), .ccw_ovf(ccw_ovf),
        .position(position)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the encoder
    logic [1:0] ab = 2'b00;
    longint n_cw = 0;
    longint n_ccw = 0;

    // Observed pulses and filtered-phase toggles
    longint cw_seen = 0;
    longint ccw_seen = 0;
    longint fa_toggles = 0;
    longint fb_toggles = 0;
    logic fa_last = 1'b0;
    logic fb_last = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cw_step) cw_seen++;
            if (ccw_step) ccw_seen++;
            if (filt_a != fa_last) fa_toggles++;
            if (filt_b != fb_last) fb_toggles++;
        end
        fa_last = filt_a;
        fb_last = filt_b;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] next_cw(input logic [1:0] v);
        case (v)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] next_ccw(input logic [1:0] v);
        case (v)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic longint exp_cnt(input longint n);
        return (n % longint'(CNT_MAX)) + 1;
    endfunction

    function automatic longint exp_ovf(input longint n);
        return (n / longint'(CNT_MAX)) % (longint'(1) << OVF_W);
    endfunction

    task automatic drive_ab(input logic [1:0] v);
        phase_a = v[1];
        phase_b = v[0];
        ab = v;
    endtask

    task automatic step_cw(input int n);
        for (int k = 0; k < n; k++) begin
            drive_ab(next_cw(ab));
            n_cw++;
            tick(HOLD);
        end
    endtask

    task automatic step_ccw(input int n);
        for (int k = 0; k < n; k++) begin
            drive_ab(next_ccw(ab));
            n_ccw++;
            tick(HOLD);
        end
    endtask

    task automatic take_snap();
        snap = 1'b1;
        tick(1);
        snap = 1'b0;
        tick(1);
    endtask

    task automatic check_model(input string req);
        chk(req, "cw pulses", cw_seen, n_cw);
        chk(req, "ccw pulses", ccw_seen, n_ccw);
        chk(req, "cw_cnt", longint'(cw_cnt), exp_cnt(n_cw));
        chk(req, "ccw_cnt", longint'(ccw_cnt), exp_cnt(n_ccw));
        chk(req, "cw_ovf", longint'(cw_ovf), exp_ovf(n_cw));
        chk(req, "ccw_ovf", longint'(ccw_ovf), exp_ovf(n_ccw));
        chk(req, "position", longint'(position), n_cw - n_ccw);
    endtask

    // R1
    task automatic t_reset();
        rst = 1'b1;
        tick(4);
        rst = 1'b0;
        tick(1);
        chk("R1", "cw_cnt", longint'(cw_cnt), 1);
        chk("R1", "ccw_cnt", longint'(ccw_cnt), 1);
        chk("R1", "cw_ovf", longint'(cw_ovf), 0);
        chk("R1", "ccw_ovf", longint'(ccw_ovf), 0);
        chk("R1", "position", longint'(position), 0);
        chk("R1", "outputs low", longint'({filt_a, filt_b, cw_step, ccw_step}), 0);
    endtask

    // R2
    task automatic t_disabled();
        dec_en = 1'b0;
        drive_ab(2'b10);
        tick(HOLD);
        chk("R2", "filt_a while off", longint'(filt_a), 0);
        drive_ab(2'b11);
        tick(HOLD);
        chk("R2", "filt_b while off", longint'(filt_b), 0);
        drive_ab(2'b00);
        tick(HOLD);
        take_snap();
        chk("R2", "cw pulses while off", cw_seen, 0);
        chk("R2", "position while off", longint'(position), 0);
        dec_en = 1'b1;
        tick(HOLD);
    endtask

    // R4, R5, R7: plain clockwise, counter-clockwise and reversal
    task automatic t_directions();
        flt_rise = 4'd2;
        flt_fall = 4'd2;
        step_cw(5);
        take_snap();
        check_model("R4 cw run");
        step_ccw(3);
        take_snap();
        check_model("R4 ccw run");
        step_cw(2);
        step_ccw(4);
        take_snap();
        check_model("R7 reversal");
    endtask

    // R5, R6, R7: runs that wrap both counters
    task automatic t_wraps();
        step_cw(20);
        take_snap();
        check_model("R6 cw wrap");
        step_ccw(16);
        take_snap();
        check_model("R6 ccw wrap");
        chk("R5", "cw_cnt in range", longint'(cw_cnt <= CNT_MAX), 1);
    endtask

    // R3: glitches at and below the filter length
    task automatic t_glitch();
        longint fb0;
        longint fa0;
        flt_rise = 4'd3;
        flt_fall = 4'd3;
        tick(HOLD);
        fb0 = fb_toggles;
        phase_b = ~ab[0];
        tick(2);
        phase_b = ab[0];
        tick(HOLD);
        phase_b = ~ab[0];
        tick(3);
        phase_b = ab[0];
        tick(HOLD);
        take_snap();
        chk("R3", "filt_b toggles after short glitches", fb_toggles, fb0);
        check_model("R3 glitch no step");
        // asymmetric lengths: rise 4, fall 1, starting from AB=00
        flt_rise = 4'd4;
        flt_fall = 4'd1;
        drive_ab(2'b00);
        tick(HOLD);
        fa0 = fa_toggles;
        phase_a = 1'b1;
        tick(4);
        phase_a = 1'b0;
        tick(HOLD);
        chk("R3", "rise glitch of rise length", fa_toggles, fa0);
        phase_a = 1'b1;
        tick(HOLD);
        n_cw++;
        phase_a = 1'b0;
        tick(2);
        phase_a = 1'b1;
        tick(HOLD);
        n_ccw++;
        n_cw++;
        ab = 2'b10;
        chk("R3", "filt_a toggles with fall length 1", fa_toggles, fa0 + 3);
        take_snap();
        check_model("R3 asymmetric");
        step_ccw(1);
    endtask

    // R9: both phases moving together
    task automatic t_double_change();
        flt_rise = 4'd2;
        flt_fall = 4'd2;
        drive_ab(2'b11);
        tick(HOLD);
        chk("R9", "filt_a after double change", longint'(filt_a), 1);
        chk("R9", "filt_b after double change", longint'(filt_b), 1);
        drive_ab(2'b00);
        tick(HOLD);
        take_snap();
        check_model("R9 no step");
    endtask

    // R8: outputs frozen without strobe
    task automatic t_snap_hold();
        longint p0;
        longint c0;
        p0 = longint'(position);
        c0 = longint'(cw_cnt);
        step_cw(3);
        chk("R8", "position frozen", longint'(position), p0);
        chk("R8", "cw_cnt frozen", longint'(cw_cnt), c0);
        take_snap();
        check_model("R8 after strobe");
    endtask

    // R7, R8: strobe held high across wraps
    task automatic t_snap_stream();
        longint prev;
        longint recon;
        longint d;
        snap = 1'b1;
        tick(2);
        prev = longint'(position);
        for (int k = 0; k < 2 * int'(CNT_MAX); k++) begin
            drive_ab(next_cw(ab));
            n_cw++;
            for (int j = 0; j < HOLD; j++) begin
                tick(1);
                d = longint'(position) - prev;
                chk("R8", "stream step size ok", longint'(d == 0 || d == 1), 1);
                recon = longint'(cw_cnt) + longint'(CNT_MAX) * longint'(cw_ovf)
                      - longint'(ccw_cnt) - longint'(CNT_MAX) * longint'(ccw_ovf);
                chk("R7", "stream position formula", longint'(position), recon);
                prev = longint'(position);
            end
        end
        snap = 1'b0;
        tick(2);
        check_model("R7 stream end");
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_directions();
        t_wraps();
        t_glitch();
        t_double_change();
        t_snap_hold();
        t_snap_stream();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule